// File: doc/BRIEF.md
# Three-Tier Prioritized Interrupt Controller

This block collects level-sensitive interrupt requests from three groups of sources (peripheral, main and critical) and folds them into one interrupt line for the processor core. Peripheral requests are ranked by a programmable 4-bit priority. The top bit of that priority selects where the peripheral cascade feeds in. Sources with the top bit set drive a "high" aggregate, which appears as code 2 in the critical tier. Sources with the top bit clear drive a "low" aggregate, which appears as code 4 in the main tier. Each tier picks one winner, and the core reads all three winners from one status word.

Software programs masks and priorities through a small register port with a single-cycle write strobe and a combinational read mux. Each tier holds its result in a two-state machine. `TIER_IDLE` moves to `TIER_HELD` on the *capture* transition: a winner exists and no clear is being written. `TIER_HELD` moves back to `TIER_IDLE` on the *release* transition: software writes a one to that tier's sticky flag. While a tier is held, its encoded winner stays frozen. The core interrupt output is high while the critical or the main tier is held. Software services the critical tier first, then the main tier, then writes the clear flags, which forces a fresh evaluation.

Top module: `hier_irq_ctrl`

## Requirements
- R1: After reset the registers read as follows.
  - Address 0 (peripheral mask) reads 0xFFFFFC00.
  - Address 1 (critical priority / main mask) reads 0x0001FFFF.
  - Address 2 (first peripheral priority register) reads 0xF0000000.
  - Addresses 3 to 6 read 0.
  - Address 7 (status) reads 0.
  - core_irq is low.
- R2: Writes to addresses 0 to 6 read back unchanged.
  - The priority of peripheral source n is the 4-bit field at bits [31-4*(n%8) -: 4] of address 2+n/8.
  - The priority of main code c is the same field of address 4+c/8.
- R3: Masking.
  - Peripheral source n is disabled when bit (31-n) of address 0 is set.
  - Main code c is disabled when bit (16-c) of address 1 is set.
  - Critical sources have no mask.
- R4: Peripheral tier arbitration.
  - Among the enabled pending peripheral sources, the highest priority value wins, and ties go to the lowest index.
  - The winner's index is reported in status bits 28:24, with its sticky flag in bit 23.
- R5: Peripheral routing.
  - An enabled pending peripheral source with priority bit 3 set makes critical code 2 pending.
  - A source with priority bit 3 clear makes main code 4 pending.
- R6: Critical tier.
  - Inputs crit_req[0], crit_req[1] and crit_req[2] are codes 0, 1 and 3.
  - Code c has a 2-bit priority at bits [31-2c -: 2] of address 1.
  - The highest priority wins, and ties go to the lowest code.
  - The result is reported with its flag in status bit 31 and its code in bits 30:29.
- R7: Main tier.
  - main_req[i] is code i for i<4 and code i+1 otherwise.
  - The highest priority wins, and ties go to the lowest code.
  - The result is reported with its flag in status bit 21 and its code in bits 20:16.
- R8: Once a tier's sticky flag is set, its code holds even when requests, masks or priorities change.
- R9: Clearing the sticky flags.
  - Writing a one to status bit 31, 23 or 21 clears that tier's flag at the write edge.
  - The tier re-captures the current winner on the next edge.
  - Zero bits and all other bits of a status write have no effect.
- R10: core_irq is high exactly while the critical flag or the main flag is set.
- R11: Timing.
  - A request change shows in the status word after the second rising edge, because of one input register followed by the status register.
  - A mask or priority write shows after the edge that follows the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| per_req | input | NUM_PER | Peripheral request levels |
| main_req | input | NUM_MAIN-1 | Direct main request levels |
| crit_req | input | NUM_CRIT-1 | Direct critical request levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| core_irq | output | 1 | Interrupt to the core |

## Verification
The bench sweeps the peripheral tier with single requests and with every pair of requests. It uses two priority tables:
- a table where all values are distinct, which isolates the highest-value rule;
- a table with many equal values, which isolates the lowest-index tie rule and exercises both cascade routes.

The bench walks all 256 critical priority settings with every critical input pending, which separates the aggregate input from the direct inputs and checks every tie order. It grows the peripheral and main masks one bit at a time, which shows which mask bit belongs to which source. Directed sequences separate the sticky hold, the per-bit clear behaviour and the two-edge request latency.

// File: rtl/hic_pkg.sv
package hic_pkg;
    localparam int REG_W = 32;

    // status word layout
    localparam int ST_CRIT_VLD  = 31;
    localparam int ST_CRIT_LSB  = 29;
    localparam int ST_CRIT_W    = 2;
    localparam int ST_PER_LSB   = 24;
    localparam int ST_PER_W     = 5;
    localparam int ST_PER_VLD   = 23;
    localparam int ST_MAIN_VLD  = 21;
    localparam int ST_MAIN_LSB  = 16;
    localparam int ST_MAIN_W    = 5;

    // reset values
    localparam logic [REG_W-1:0] PER_MASK_RST  = 32'hFFFF_FC00;
    localparam logic [REG_W-1:0] CRIT_MAIN_RST = 32'h0001_FFFF;
    localparam logic [REG_W-1:0] PER_PRI0_RST  = 32'hF000_0000;

    typedef enum logic {
        TIER_IDLE = 1'b0,
        TIER_HELD = 1'b1
    } tier_state_e;
endpackage

// File: rtl/hic_arbiter.sv
module hic_arbiter #(
    parameter int N  = 16,
    parameter int PW = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]    pend,
    input  logic [N*PW-1:0] prio,
    output logic            valid,
    output logic [IW-1:0]   idx,
    output logic [PW-1:0]   win_prio
);
    logic [PW-1:0] best;

    // strict comparison keeps the lowest index on a tie
    always_comb begin
        valid = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && (!valid || prio[i*PW +: PW] > best)) begin
                valid = 1'b1;
                idx   = IW'(i);
                best  = prio[i*PW +: PW];
            end
        end
    end

    assign win_prio = best;
endmodule

// File: rtl/hic_tier_latch.sv
module hic_tier_latch
    import hic_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          win_vld,
    input  logic [CW-1:0] win_code,
    input  logic          clr,
    output logic          held,
    output logic [CW-1:0] code
);
    tier_state_e   state_q, state_d;
    logic [CW-1:0] code_q, code_d;

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            TIER_IDLE: begin
                if (win_vld && !clr) begin       // capture
                    state_d = TIER_HELD;
                    code_d  = win_code;
                end
            end
            TIER_HELD: begin
                if (clr) begin                   // release
                    state_d = TIER_IDLE;
                end
            end
            default: state_d = TIER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TIER_IDLE;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    always_comb begin
        held = (state_q == TIER_HELD);
        code = held ? code_q : '0;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !clr) |=> (held && $stable(code))); // R8
    AST_CLR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && clr) |=> !held); // R9
    AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && win_vld && !clr) |=> (held && code == $past(win_code))); // R9
endmodule

// File: rtl/hier_irq_ctrl.sv
module hier_irq_ctrl
    import hic_pkg::*;
#(
    parameter int NUM_PER  = 16,
    parameter int NUM_MAIN = 17,
    parameter int LO_CODE  = 4,
    parameter int NUM_CRIT = 4,
    parameter int HI_CODE  = 2,
    parameter int AW       = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PER-1:0]    per_req,
    input  logic [NUM_MAIN-2:0]   main_req,
    input  logic [NUM_CRIT-2:0]   crit_req,
    input  logic                  reg_wr,
    input  logic [AW-1:0]         reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  core_irq
);
    localparam int PER_REGS    = (NUM_PER + 7) / 8;
    localparam int MAIN_REGS   = (NUM_MAIN + 7) / 8;
    localparam int ADDR_PMASK  = 0;
    localparam int ADDR_CMAIN  = 1;
    localparam int PER_BASE    = 2;
    localparam int MAIN_BASE   = PER_BASE + PER_REGS;
    localparam int ADDR_STATUS = MAIN_BASE + MAIN_REGS;
    localparam int PIW         = $clog2(NUM_PER);
    localparam int MIW         = $clog2(NUM_MAIN);
    localparam int CIW         = $clog2(NUM_CRIT);

    // ---------------- registers ----------------
    logic [REG_W-1:0] per_mask_q, crit_main_q;
    logic [REG_W-1:0] per_pri_q  [PER_REGS];
    logic [REG_W-1:0] main_pri_q [MAIN_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_mask_q  <= PER_MASK_RST;
            crit_main_q <= CRIT_MAIN_RST;
            for (int i = 0; i < PER_REGS; i++)
                per_pri_q[i] <= (i == 0) ? PER_PRI0_RST : '0;
            for (int i = 0; i < MAIN_REGS; i++)
                main_pri_q[i] <= '0;
        end else if (reg_wr) begin
            if (reg_addr == AW'(ADDR_PMASK)) per_mask_q  <= reg_wdata;
            if (reg_addr == AW'(ADDR_CMAIN)) crit_main_q <= reg_wdata;
            for (int i = 0; i < PER_REGS; i++)
                if (reg_addr == AW'(PER_BASE + i)) per_pri_q[i] <= reg_wdata;
            for (int i = 0; i < MAIN_REGS; i++)
                if (reg_addr == AW'(MAIN_BASE + i)) main_pri_q[i] <= reg_wdata;
        end
    end

    // ---------------- request input registers ----------------
    logic [NUM_PER-1:0]  per_req_q;
    logic [NUM_MAIN-2:0] main_req_q;
    logic [NUM_CRIT-2:0] crit_req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_req_q  <= '0;
            main_req_q <= '0;
            crit_req_q <= '0;
        end else begin
            per_req_q  <= per_req;
            main_req_q <= main_req;
            crit_req_q <= crit_req;
        end
    end

    // ---------------- peripheral tier ----------------
    logic [NUM_PER-1:0]   per_pend, per_hi;
    logic [NUM_PER*4-1:0] per_prio;
    logic                 hi_agg, lo_agg;

    for (genvar n = 0; n < NUM_PER; n++) begin : g_per
        assign per_prio[n*4 +: 4] = per_pri_q[n/8][31-4*(n%8) -: 4];
        assign per_pend[n]        = per_req_q[n] & ~per_mask_q[31-n];
        assign per_hi[n]          = per_prio[n*4+3];
    end

    assign hi_agg = |(per_pend & per_hi);
    assign lo_agg = |(per_pend & ~per_hi);

    logic           per_vld;
    logic [PIW-1:0] per_idx;
    logic [3:0]     per_win_prio;

    hic_arbiter #(.N(NUM_PER), .PW(4), .IW(PIW)) u_per_arb (
        .pend(per_pend), .prio(per_prio),
        .valid(per_vld), .idx(per_idx), .win_prio(per_win_prio)
    );

    // ---------------- main tier ----------------
    logic [NUM_MAIN-1:0]   main_raw, main_pend;
    logic [NUM_MAIN*4-1:0] main_prio;

    for (genvar c = 0; c < NUM_MAIN; c++) begin : g_main
        if (c == LO_CODE) begin : g_agg
            assign main_raw[c] = lo_agg;
        end else if (c < LO_CODE) begin : g_low
            assign main_raw[c] = main_req_q[c];
        end else begin : g_high
            assign main_raw[c] = main_req_q[c-1];
        end
        assign main_pend[c]        = main_raw[c] & ~crit_main_q[NUM_MAIN-1-c];
        assign main_prio[c*4 +: 4] = main_pri_q[c/8][31-4*(c%8) -: 4];
    end

    logic           main_vld;
    logic [MIW-1:0] main_idx;
    logic [3:0]     main_win_prio;

    hic_arbiter #(.N(NUM_MAIN), .PW(4), .IW(MIW)) u_main_arb (
        .pend(main_pend), .prio(main_prio),
        .valid(main_vld), .idx(main_idx), .win_prio(main_win_prio)
    );

    // ---------------- critical tier ----------------
    logic [NUM_CRIT-1:0]   crit_pend;
    logic [NUM_CRIT*2-1:0] crit_prio;

    for (genvar c = 0; c < NUM_CRIT; c++) begin : g_crit
        if (c == HI_CODE) begin : g_agg
            assign crit_pend[c] = hi_agg;
        end else if (c < HI_CODE) begin : g_low
            assign crit_pend[c] = crit_req_q[c];
        end else begin : g_high
            assign crit_pend[c] = crit_req_q[c-1];
        end
        assign crit_prio[c*2 +: 2] = crit_main_q[31-2*c -: 2];
    end

    logic           crit_vld;
    logic [CIW-1:0] crit_idx;
    logic [1:0]     crit_win_prio;

    hic_arbiter #(.N(NUM_CRIT), .PW(2), .IW(CIW)) u_crit_arb (
        .pend(crit_pend), .prio(crit_prio),
        .valid(crit_vld), .idx(crit_idx), .win_prio(crit_win_prio)
    );

    // ---------------- sticky status ----------------
    logic status_wr, clr_crit, clr_per, clr_main;
    assign status_wr = reg_wr && (reg_addr == AW'(ADDR_STATUS));
    assign clr_crit  = status_wr && reg_wdata[ST_CRIT_VLD];
    assign clr_per   = status_wr && reg_wdata[ST_PER_VLD];
    assign clr_main  = status_wr && reg_wdata[ST_MAIN_VLD];

    logic           crit_held, per_held, main_held;
    logic [CIW-1:0] crit_code;
    logic [PIW-1:0] per_code;
    logic [MIW-1:0] main_code;

    hic_tier_latch #(.CW(CIW)) u_crit_latch (
        .clk(clk), .rst_n(rst_n), .win_vld(crit_vld), .win_code(crit_idx),
        .clr(clr_crit), .held(crit_held), .code(crit_code)
    );
    hic_tier_latch #(.CW(PIW)) u_per_latch (
        .clk(clk), .rst_n(rst_n), .win_vld(per_vld), .win_code(per_idx),
        .clr(clr_per), .held(per_held), .code(per_code)
    );
    hic_tier_latch #(.CW(MIW)) u_main_latch (
        .clk(clk), .rst_n(rst_n), .win_vld(main_vld), .win_code(main_idx),
        .clr(clr_main), .held(main_held), .code(main_code)
    );

    logic [REG_W-1:0] status_word;
    always_comb begin
        status_word = '0;
        status_word[ST_CRIT_VLD]                      = crit_held;
        status_word[ST_CRIT_LSB +: ST_CRIT_W]         = ST_CRIT_W'(crit_code);
        status_word[ST_PER_LSB +: ST_PER_W]           = ST_PER_W'(per_code);
        status_word[ST_PER_VLD]                       = per_held;
        status_word[ST_MAIN_VLD]                      = main_held;
        status_word[ST_MAIN_LSB +: ST_MAIN_W]         = ST_MAIN_W'(main_code);
    end

    assign core_irq = crit_held | main_held;

    // ---------------- read mux ----------------
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == AW'(ADDR_PMASK))  reg_rdata = per_mask_q;
        if (reg_addr == AW'(ADDR_CMAIN))  reg_rdata = crit_main_q;
        if (reg_addr == AW'(ADDR_STATUS)) reg_rdata = status_word;
        for (int i = 0; i < PER_REGS; i++)
            if (reg_addr == AW'(PER_BASE + i)) reg_rdata = per_pri_q[i];
        for (int i = 0; i < MAIN_REGS; i++)
            if (reg_addr == AW'(MAIN_BASE + i)) reg_rdata = main_pri_q[i];
    end

    // ---------------- assertions ----------------
    AST_PER_WIN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        per_vld |-> per_pend[per_idx]); // R4
    AST_HI_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (per_vld && per_win_prio[3]) |-> crit_vld); // R5
    AST_LO_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (per_vld && !per_win_prio[3] && !crit_main_q[NUM_MAIN-1-LO_CODE]) |-> main_vld); // R5
    AST_MAIN_CODE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        main_held |-> (main_code < MIW'(NUM_MAIN))); // R7
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_irq) |-> $past(crit_vld || main_vld)); // R10
endmodule

// File: tb/hier_irq_ctrl_bench.sv
`timescale 1ns/1ps
module hier_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] preq = '0;
    logic [15:0] mreq = '0;
    logic [2:0]  creq = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        core_irq;

    always #5 clk = ~clk;

    hier_irq_ctrl u_hier_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .per_req(preq), .main_req(mreq),
        .crit_req(creq), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_irq(core_irq)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    int pprio [16];
    int mprio [17];
    logic [31:0] pmask = 32'hFFFF_FC00;
    logic [31:0] cm    = 32'h0001_FFFF;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic push_per();
        for (int r = 0; r < 2; r++) begin
            logic [31:0] d = '0;
            for (int k = 0; k < 8; k++)
                d = d | (32'(pprio[r*8+k] & 15) << (28 - 4*k));
            wr(4'(2 + r), d);
        end
    endtask

    task automatic push_main();
        for (int r = 0; r < 3; r++) begin
            logic [31:0] d = '0;
            for (int k = 0; k < 8; k++)
                if (r*8 + k < 17)
                    d = d | (32'(mprio[r*8+k] & 15) << (28 - 4*k));
            wr(4'(4 + r), d);
        end
    endtask

    // model of the status word built from the requirements
    function automatic logic [31:0] exp_status();
        int pb = -1, cb = -1, mb = -1;
        int cbp = 0, mbp = 0;
        bit hi = 0, lo = 0;
        logic [31:0] s = '0;
        for (int n = 0; n < 16; n++) begin
            if (preq[n] && !pmask[31-n]) begin
                if (pprio[n] >= 8) hi = 1; else lo = 1;
                if (pb < 0 || pprio[n] > pprio[pb]) pb = n;
            end
        end
        for (int c = 0; c < 4; c++) begin
            bit pend = (c == 2) ? hi : creq[(c < 2) ? c : c - 1];
            int p = int'((cm >> (30 - 2*c)) & 32'd3);
            if (pend && (cb < 0 || p > cbp)) begin cb = c; cbp = p; end
        end
        for (int c = 0; c < 17; c++) begin
            bit pend = (c == 4) ? lo : mreq[(c < 4) ? c : c - 1];
            if (cm[16-c]) pend = 0;
            if (pend && (mb < 0 || mprio[c] > mbp)) begin mb = c; mbp = mprio[c]; end
        end
        if (cb >= 0) begin s[31] = 1'b1; s[30:29] = 2'(cb); end
        if (pb >= 0) begin s[23] = 1'b1; s[28:24] = 5'(pb); end
        if (mb >= 0) begin s[21] = 1'b1; s[20:16] = 5'(mb); end
        return s;
    endfunction

    task automatic refresh();
        repeat (2) @(negedge clk);
        wr(4'd7, 32'h80A0_0000);
        @(negedge clk);
    endtask

    task automatic check_state(input string tag);
        logic [31:0] s, e;
        rd(4'd7, s);
        e = exp_status();
        chk(tag, s, e);
        chk({tag, " R10 irq"}, {31'b0, core_irq}, {31'b0, e[31] | e[21]});
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] rst_exp [8];
        rst_exp = '{32'hFFFF_FC00, 32'h0001_FFFF, 32'hF000_0000, 0, 0, 0, 0, 0};
        for (int i = 0; i < 16; i++) pprio[i] = 0;
        for (int i = 0; i < 17; i++) mprio[i] = 0;
        pprio[0] = 15;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        for (int a = 0; a < 8; a++) begin
            rd(4'(a), v);
            chk($sformatf("R1 reset addr %0d", a), v, rst_exp[a]);
        end
        chk("R1 reset irq", {31'b0, core_irq}, 32'd0);

        // R2 readback and field placement
        wr(4'd3, 32'h1234_5678); rd(4'd3, v); chk("R2 per pri readback", v, 32'h1234_5678);
        wr(4'd6, 32'hA000_0000); rd(4'd6, v); chk("R2 main pri readback", v, 32'hA000_0000);
        pmask = 0; wr(4'd0, pmask); rd(4'd0, v); chk("R2 mask readback", v, 0);
        cm = 0; wr(4'd1, cm); rd(4'd1, v); chk("R2 cmain readback", v, 0);
        push_main();

        // R4/R5 distinct priorities: singles and all pairs
        for (int n = 0; n < 16; n++) pprio[n] = (n*7 + 3) % 16;
        push_per();
        for (int n = 0; n < 16; n++) begin
            preq = 16'(1) << n; refresh();
            check_state($sformatf("R4 R5 single %0d", n));
        end
        for (int a = 0; a < 16; a++)
            for (int b = a + 1; b < 16; b++) begin
                preq = (16'(1) << a) | (16'(1) << b); refresh();
                check_state($sformatf("R4 pair %0d %0d", a, b));
            end

        // R4/R5 tied priorities
        for (int n = 0; n < 16; n++) pprio[n] = (n % 3) * 5;
        push_per();
        for (int a = 0; a < 16; a++)
            for (int b = a + 1; b < 16; b++) begin
                preq = (16'(1) << a) | (16'(1) << b); refresh();
                check_state($sformatf("R4 R5 tie pair %0d %0d", a, b));
            end

        // R3 peripheral mask grows from the top
        preq = 16'hFFFF;
        for (int k = 0; k <= 16; k++) begin
            pmask = (k == 0) ? 32'd0 : (32'hFFFF_FFFF << (32 - k));
            wr(4'd0, pmask); refresh();
            check_state($sformatf("R3 per mask %0d", k));
        end
        pmask = 0; wr(4'd0, pmask);

        // R6 critical priorities, all critical inputs and HI aggregate pending
        preq = 16'h0004; creq = 3'b111;
        for (int p = 0; p < 256; p++) begin
            cm = 32'(p) << 24; wr(4'd1, cm); refresh();
            check_state($sformatf("R6 crit prio %0h", p));
        end
        cm = 0; wr(4'd1, cm);
        preq = 0; creq = 0;

        // R7 main tier
        for (int c = 0; c < 17; c++) mprio[c] = (c*5 + 1) % 16;
        push_main();
        for (int i = 0; i < 16; i++) begin
            mreq = 16'(1) << i; refresh();
            check_state($sformatf("R7 main single %0d", i));
        end
        for (int i = 0; i < 16; i++) begin
            mreq = (16'(1) << i) | (16'(1) << ((i + 5) % 16)); refresh();
            check_state($sformatf("R7 main pair %0d", i));
        end
        // R3 main mask grows from code 0
        mreq = 16'hFFFF; preq = 16'h0001;
        for (int k = 0; k <= 17; k++) begin
            cm = (k == 0) ? 32'd0 : ((32'h1FFFF >> (17 - k)) << (17 - k));
            wr(4'd1, cm); refresh();
            check_state($sformatf("R3 main mask %0d", k));
        end
        cm = 0; wr(4'd1, cm);

        // R8 / R9 sticky hold and clear
        mreq = 0; preq = 0; refresh();
        check_state("R10 idle");
        mreq = 16'h0001; repeat (3) @(negedge clk);
        rd(4'd7, v); chk("R8 capture code 0", v, 32'h0020_0000);
        mreq = 16'h0005; repeat (3) @(negedge clk);
        rd(4'd7, v); chk("R8 hold code 0", v, 32'h0020_0000);
        wr(4'd7, 32'h0000_0000); rd(4'd7, v); chk("R9 zero write", v, 32'h0020_0000);
        wr(4'd7, 32'h8080_0000); rd(4'd7, v); chk("R9 other flag write", v, 32'h0020_0000);
        wr(4'd7, 32'h0020_0000); rd(4'd7, v); chk("R9 cleared", v, 32'h0000_0000);
        chk("R10 irq low after clear", {31'b0, core_irq}, 32'd0);
        @(negedge clk); rd(4'd7, v); chk("R9 recapture code 2", v, 32'h0022_0000);

        // R11 request latency
        mreq = 0; refresh();
        creq = 3'b001;
        @(negedge clk); rd(4'd7, v); chk("R11 one edge", v, 32'h0);
        @(negedge clk); rd(4'd7, v); chk("R11 two edges", v, 32'h8000_0000);
        chk("R10 irq on crit", {31'b0, core_irq}, 32'd1);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule